// File: doc/BRIEF.md
# Key Combination Reset Detector

This block watches a group of already-debounced, active-high key inputs. It fires when a programmed subset of them is held down together for a programmed number of slow-clock ticks. Time is measured only on `tick_i`, a one-cycle strobe from a free-running slow timebase, so all durations are set in slow ticks rather than in core clock cycles.

Each detection produces a one-cycle `det_o` pulse. It also triggers whichever actions are enabled in `act_en_i`:
- an active-low reset pulse of programmable width on `ext_rst_no`;
- a sticky interrupt status bit, `irq_status_o`, which software clears with `irq_clr_i`.

The combination must be released before it can fire again. An all-zero select mask disables detection.

Top module: `kc_combo_reset`

## Requirements
- R1: Key i is part of the combination when bit i of `sel_mask_i` is 1. The combination counts as held when every selected key reads 1. Unselected keys are ignored.
- R2: A detection fires on the tick that brings the count of ticks, seen while the combination is held without a break, up to `hold_ticks_i`. A value of 0 behaves as 1. `det_o` is high for the single clock cycle after that tick.
- R3: Releasing any selected key before the hold completes resets the tick count to zero.
- R4: When `sel_mask_i` is all zero, no detection ever fires.
- R5: One continuous hold gives at most one detection. Further ticks while the keys stay held give none, until the combination has been released and pressed again.
- R6: Bit 0 of `act_en_i` enables the reset pulse and bit 1 enables the interrupt status. An action whose bit is 0 leaves its output unchanged on a detection.
- R7: On a detection with the reset pulse enabled, `ext_rst_no` goes low in the following cycle. It stays low for exactly `pulse_ticks_i` ticks and then returns high. A width of 0 produces no pulse. The idle level is high.
- R8: `irq_status_o` is set by a detection with the interrupt enabled. It stays set until `irq_clr_i` is pulsed, and a set in the same cycle wins over a clear.
- R9: While `rst_ni` is low, `ext_rst_no` is 1, and `irq_status_o` and `det_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle slow timebase strobe |
| keys_i | input | NUM_KEYS | Debounced key levels, 1 = pressed |
| sel_mask_i | input | NUM_KEYS | Keys that form the combination |
| hold_ticks_i | input | HOLD_W | Hold time in ticks |
| act_en_i | input | 2 | Action enables: bit 0 reset pulse, bit 1 interrupt |
| pulse_ticks_i | input | PULSE_W | Reset pulse width in ticks |
| irq_clr_i | input | 1 | Clears the interrupt status |
| ext_rst_no | output | 1 | Active-low external reset output |
| irq_status_o | output | 1 | Sticky interrupt status |
| det_o | output | 1 | One-cycle detection strobe |

## Verification
The assertions assume that `tick_i` is a single-cycle strobe. They also assume that the configuration inputs change only while the combination is released, because a detection is judged against the mask and enables of the cycle before it. The stimulus meets both assumptions:
- every tick is one cycle high followed by at least one cycle low;
- mask, hold, width and enables are written only after all keys are released and before the combination is pressed.

// File: rtl/kc_pkg.sv
package kc_pkg;
  localparam int unsigned ACT_W   = 2;
  localparam int unsigned ACT_RST = 0;
  localparam int unsigned ACT_IRQ = 1;
endpackage

// File: rtl/kc_match.sv
module kc_match #(
  parameter int unsigned NUM_KEYS = 5
) (
  input  logic [NUM_KEYS-1:0] keys_i,
  input  logic [NUM_KEYS-1:0] sel_mask_i,
  output logic                held_o
);
  logic [NUM_KEYS-1:0] hit;

  for (genvar i = 0; i < NUM_KEYS; i++) begin : g_key
    assign hit[i] = keys_i[i] | ~sel_mask_i[i];
  end

  // empty mask disables the detector
  assign held_o = (|sel_mask_i) & (&hit);
endmodule

// File: rtl/kc_hold_timer.sv
module kc_hold_timer #(
  parameter int unsigned HOLD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              held_i,
  input  logic [HOLD_W-1:0] hold_ticks_i,
  output logic              det_o
);
  localparam int unsigned CW = HOLD_W + 1;

  logic [HOLD_W-1:0] cnt_q;
  logic              fired_q;
  logic              det_q;
  logic [CW-1:0]     cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      det_q   <= 1'b0;
    end else begin
      det_q <= 1'b0;
      if (!held_i) begin
        cnt_q   <= '0;
        fired_q <= 1'b0;
      end else if (tick_i && !fired_q) begin
        if (cnt_nxt >= {1'b0, hold_ticks_i}) begin
          fired_q <= 1'b1;
          det_q   <= 1'b1;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_nxt[HOLD_W-1:0];
        end
      end
    end
  end

  assign det_o = det_q;
endmodule

// File: rtl/kc_pulse_gen.sv
module kc_pulse_gen #(
  parameter int unsigned PULSE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               load_i,
  input  logic [PULSE_W-1:0] width_i,
  output logic               pulse_no
);
  logic [PULSE_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
    end else if (load_i) begin
      rem_q <= width_i;
    end else if (tick_i && rem_q != '0) begin
      rem_q <= rem_q - PULSE_W'(1);
    end
  end

  assign pulse_no = (rem_q == '0);
endmodule

// File: rtl/kc_combo_reset.sv
module kc_combo_reset
  import kc_pkg::*;
#(
  parameter int unsigned NUM_KEYS = 5,
  parameter int unsigned HOLD_W   = 16,
  parameter int unsigned PULSE_W  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [NUM_KEYS-1:0] keys_i,
  input  logic [NUM_KEYS-1:0] sel_mask_i,
  input  logic [HOLD_W-1:0]   hold_ticks_i,
  input  logic [ACT_W-1:0]    act_en_i,
  input  logic [PULSE_W-1:0]  pulse_ticks_i,
  input  logic                irq_clr_i,
  output logic                ext_rst_no,
  output logic                irq_status_o,
  output logic                det_o
);
  logic held;
  logic det;
  logic irq_q;

  kc_match #(.NUM_KEYS(NUM_KEYS)) u_match (
    .keys_i     (keys_i),
    .sel_mask_i (sel_mask_i),
    .held_o     (held)
  );

  kc_hold_timer #(.HOLD_W(HOLD_W)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .held_i       (held),
    .hold_ticks_i (hold_ticks_i),
    .det_o        (det)
  );

  kc_pulse_gen #(.PULSE_W(PULSE_W)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .load_i   (det & act_en_i[ACT_RST]),
    .width_i  (pulse_ticks_i),
    .pulse_no (ext_rst_no)
  );

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      irq_q <= 1'b0;
    else if (det && act_en_i[ACT_IRQ]) irq_q <= 1'b1;
    else if (irq_clr_i)               irq_q <= 1'b0;
  end

  assign irq_status_o = irq_q;
  assign det_o        = det;
endmodule

// File: rtl/kc_combo_reset_chk.sv
module kc_combo_reset_chk #(
  parameter int unsigned NUM_KEYS = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                tick_i,
  input logic [NUM_KEYS-1:0] sel_mask_i,
  input logic [1:0]          act_en_i,
  input logic                irq_clr_i,
  input logic                ext_rst_no,
  input logic                irq_status_o,
  input logic                det_o
);
  AST_DET_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_o |-> $past(tick_i)); // R2
  AST_NO_DET_EMPTY_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_o |-> ($past(sel_mask_i) != '0)); // R4
  AST_DET_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_o |=> !det_o); // R5
  AST_RST_FALL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ext_rst_no) |-> $past(det_o && act_en_i[0])); // R7
  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_status_o) |-> $past(det_o && act_en_i[1])); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_status_o && !irq_clr_i) |=> irq_status_o); // R8
  AST_IRQ_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_o && act_en_i[1]) |=> irq_status_o); // R8
endmodule

bind kc_combo_reset kc_combo_reset_chk #(.NUM_KEYS(NUM_KEYS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .sel_mask_i   (sel_mask_i),
  .act_en_i     (act_en_i),
  .irq_clr_i    (irq_clr_i),
  .ext_rst_no   (ext_rst_no),
  .irq_status_o (irq_status_o),
  .det_o        (det_o)
);

// File: tb/kc_combo_reset_bench.sv
module kc_combo_reset_bench;
  localparam int unsigned NK = 5;

  typedef struct packed {
    logic [4:0] sel;
    logic [4:0] keys;
    logic [7:0] hold;
    logic [7:0] nticks;
    logic       exp;
  } vec_t;

  // interrupt-only action; exp = irq_status_o after nticks ticks
  localparam vec_t VEC [8] = '{
    '{5'b00011, 5'b00011, 8'd4,   8'd4,   1'b1},  // R1 R2 exact hold
    '{5'b00011, 5'b00011, 8'd4,   8'd3,   1'b0},  // R2 one short
    '{5'b00011, 5'b00001, 8'd2,   8'd10,  1'b0},  // R1 partial combo
    '{5'b00000, 5'b11111, 8'd1,   8'd5,   1'b0},  // R4 empty mask
    '{5'b10100, 5'b11111, 8'd3,   8'd3,   1'b1},  // R1 extra keys ignored
    '{5'b11111, 5'b11111, 8'd0,   8'd1,   1'b1},  // R2 zero hold as one
    '{5'b01000, 5'b01000, 8'd1,   8'd0,   1'b0},  // R2 no tick
    '{5'b10001, 5'b10001, 8'd200, 8'd200, 1'b1}   // R2 long hold
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tick = 1'b0;
  logic [NK-1:0] keys = '0;
  logic [NK-1:0] sel = '0;
  logic [15:0]   hold = '0;
  logic [1:0]    act = '0;
  logic [15:0]   width = '0;
  logic          clr = 1'b0;
  logic          ext_rst_n, irq, det;

  int n_chk = 0, n_fail = 0;
  int det_cnt = 0, low_ticks = 0, low_cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  kc_combo_reset #(.NUM_KEYS(NK)) u_kc_combo_reset (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .keys_i(keys),
    .sel_mask_i(sel), .hold_ticks_i(hold), .act_en_i(act),
    .pulse_ticks_i(width), .irq_clr_i(clr),
    .ext_rst_no(ext_rst_n), .irq_status_o(irq), .det_o(det)
  );

  always @(negedge clk) begin
    if (det) det_cnt++;
    if (!ext_rst_n) low_cycles++;
    if (!ext_rst_n && tick) low_ticks++;
  end

  task automatic check(input string req, input int act_v, input int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic clear_irq();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  initial begin
    cyc(2);
    check("R9 ext_rst_no", ext_rst_n, 1);
    check("R9 irq_status", irq, 0);
    check("R9 det", det, 0);
    @(negedge clk) rst_ni = 1'b1;
    cyc(2);

    for (int v = 0; v < 8; v++) begin
      keys = '0;
      clear_irq();
      sel = VEC[v].sel; hold = 16'(VEC[v].hold); act = 2'b10;
      cyc(1);
      keys = VEC[v].keys;
      ticks(int'(VEC[v].nticks));
      cyc(2);
      check($sformatf("R1/R2/R4 vector %0d", v), irq, int'(VEC[v].exp));
    end
    check("R6 no reset pulse with reset action off", low_cycles, 0);

    // R3: release restarts the count
    keys = '0; clear_irq();
    sel = 5'b00011; hold = 16'd5; act = 2'b10;
    cyc(1); keys = 5'b00011;
    ticks(3);
    keys = 5'b00001; cyc(1); keys = 5'b00011;
    ticks(4); cyc(2);
    check("R3 no detection after restart", irq, 0);
    ticks(1); cyc(2);
    check("R3 fires after full hold", irq, 1);

    // R5 and R8
    keys = '0; clear_irq();
    hold = 16'd2; cyc(1);
    det_cnt = 0;
    keys = 5'b00011; ticks(2); cyc(2);
    check("R2 one det pulse", det_cnt, 1);
    clear_irq();
    check("R8 clear", irq, 0);
    ticks(5); cyc(2);
    check("R5 no refire while held", det_cnt, 1);
    check("R5 status stays clear", irq, 0);
    keys = '0; cyc(1); keys = 5'b00011; ticks(2); cyc(2);
    check("R5 refire after re-press", det_cnt, 2);
    cyc(20);
    check("R8 sticky", irq, 1);

    // R7: reset pulse width
    keys = '0; clear_irq();
    sel = 5'b00001; hold = 16'd1; act = 2'b01; width = 16'd7;
    cyc(1);
    low_ticks = 0;
    keys = 5'b00001; ticks(1);
    cyc(1);
    check("R7 low after detection", ext_rst_n, 0);
    ticks(12); cyc(1);
    check("R7 low for exact ticks", low_ticks, 7);
    check("R7 released", ext_rst_n, 1);
    check("R6 irq untouched with irq action off", irq, 0);

    // R7: zero width
    keys = '0; width = 16'd0; cyc(1);
    low_ticks = 0; low_cycles = 0;
    keys = 5'b00001; ticks(4); cyc(2);
    check("R7 zero width no pulse", low_cycles, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule